// File: doc/BRIEF.md
# Width-Adapting ROM and Peripheral Bus Controller

This block sits between a 64-bit internal memory request port and an external ROM or peripheral bus whose data path is 8, 16, 32 or 64 bits wide. The device width comes from a configuration input. Every read is served as whole aligned doublewords. The controller runs as many narrow device cycles as one doubleword needs and packs the returned bytes into a single 64-bit response. Two-beat and four-beat read bursts walk through their 16-byte or 32-byte aligned window and wrap around inside it.

Writes are accepted only when they match the device exactly: one beat, exactly as many bytes as the device is wide, placed on an address aligned to that width. Any other write runs no device cycle at all. It is answered straight away with both a select error and a write error. When logging is enabled, the first failing address is kept until it is cleared. Each device cycle keeps the chip select and its strobe asserted for a programmable number of wait clocks.

The configuration inputs are sampled when a request is accepted. They must not change while a transaction is in flight.

Top module: `rombus_adapter`

## Requirements
- R1: A read returns the whole doubleword that holds the request address, packed little-endian (the lowest device address goes in bits 7:0). This holds whatever the byte enables of the request are. Device byte lanes above the configured width are ignored.
- R2: `cfg_width` encodes the device width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. A doubleword takes 8, 4, 2 or 1 device cycles. These start at the aligned doubleword address, and the address rises by the device width in bytes each time.
- R3: `req_burst` = 01 is a two-beat read. It returns two doublewords, starting with the one holding the address and wrapping inside the aligned 16-byte block.
- R4: `req_burst` = 10 or 11 is a four-beat read. It returns four doublewords, starting with the one holding the address and wrapping inside the aligned 32-byte block.
- R5: Every device cycle keeps `dev_cs_n` and its strobe low for `cfg_wait`+1 clocks, and the address stays stable throughout. Read data is taken in the last of these clocks.
- R6: Read cycles drive `dev_oe_n` low and write cycles drive `dev_we_n` low, never both at once. With no transaction in flight, the chip select and both strobes are high.
- R7: A write is legal when all of the following hold: `req_burst` = 00, the address is aligned to the device width, and `req_be` has exactly the device-width bytes set starting at byte lane `req_addr[2:0]`. A legal write runs one device cycle at `req_addr`, with the data of those lanes on the low lanes of `dev_wdata`. It then gives a response with no error.
- R8: An illegal write runs no device cycle. In the clock after acceptance it responds with `rsp_valid`, `rsp_last`, `rsp_sel_err` and `rsp_wr_err` all high.
- R9: With `cfg_log_en` high, an illegal write records its address in `log_addr` and sets `log_valid`, but only if no entry is already held. Later errors leave the entry unchanged, and `log_clr` empties it. With `cfg_log_en` low, nothing is recorded.
- R10: `req_ready` is high only while no transaction is in flight. `rsp_last` marks the final response of each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Device width code |
| cfg_wait | input | WAIT_W | Wait clocks added to each device cycle |
| cfg_log_en | input | 1 | Enable error address logging |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_burst | input | 2 | Beats: 00 one, 01 two, 1x four |
| req_be | input | 8 | Byte enables (checked for writes only) |
| req_wdata | input | 64 | Write data on its natural byte lanes |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Assembled read doubleword |
| rsp_last | output | 1 | Final response of the transaction |
| rsp_sel_err | output | 1 | Select error on this response |
| rsp_wr_err | output | 1 | Write error on this response |
| dev_addr | output | ADDR_W | Device byte address |
| dev_cs_n | output | 1 | Device chip select, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_we_n | output | 1 | Device write enable, active low |
| dev_wdata | output | 64 | Device write data, low lanes used |
| dev_rdata | input | 64 | Device read data, low lanes used |
| log_clr | input | 1 | Clear the error log |
| log_valid | output | 1 | Error log holds an address |
| log_addr | output | ADDR_W | First failing write address |

## Verification
The bench builds the controller with ADDR_W = 16 and WAIT_W = 4. The 16-bit address keeps the byte-pattern device model small. The 4-bit wait field makes the full 0 to 15 wait range reachable, and the bench exercises 0, 1, 2 and 3. All four width codes are applied through the configuration input. Reads start in the middle of both burst windows so that wrapping is forced, and the bench drives filler bytes on the unused device lanes. Legal writes, misaligned writes, wrong-size writes and burst writes are each checked against the device strobe count and the state of the error log.

// File: rtl/rba_pkg.sv
package rba_pkg;

  typedef enum logic { ST_IDLE = 1'b0, ST_ACT = 1'b1 } seq_state_e;

  // bytes moved per device cycle for a width code
  function automatic logic [3:0] width_bytes(input logic [1:0] w);
    return 4'd1 << w;
  endfunction

  // byte lanes touched by one device cycle at a given offset
  function automatic logic [7:0] lane_mask(input logic [1:0] w, input logic [2:0] off);
    logic [7:0] base;
    case (w)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << off;
  endfunction

  // offset is a multiple of the device width
  function automatic logic width_aligned(input logic [1:0] w, input logic [2:0] off);
    case (w)
      2'd0:    return 1'b1;
      2'd1:    return off[0] == 1'b0;
      2'd2:    return off[1:0] == 2'b00;
      default: return off == 3'b000;
    endcase
  endfunction

  // doubleword index bits that wrap inside the burst window; also beats-1
  function automatic logic [1:0] burst_wrap(input logic [1:0] b);
    case (b)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/rba_wr_check.sv
module rba_wr_check
  import rba_pkg::*;
(
  input  logic [1:0] width,
  input  logic [2:0] addr_lo,
  input  logic [1:0] burst,
  input  logic [7:0] be,
  output logic       legal
);

  logic single_beat;
  logic aligned_ok;
  logic size_ok;

  always_comb begin
    single_beat = (burst == 2'b00);
    aligned_ok  = width_aligned(width, addr_lo);
    size_ok     = (be == lane_mask(width, addr_lo));
    legal       = single_beat && aligned_ok && size_ok;
  end

endmodule

// File: rtl/rba_pack.sv
module rba_pack
  import rba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic [1:0]  width,
  input  logic [2:0]  off,
  input  logic [63:0] dev_rdata,
  output logic [63:0] asm_next
);

  logic [63:0] asm_q;
  logic [7:0]  lmask;
  logic [63:0] m64;
  logic [63:0] shifted;

  assign lmask = lane_mask(width, off);

  for (genvar g = 0; g < 8; g++) begin : g_lane
    assign m64[g*8 +: 8] = {8{lmask[g]}};
  end

  always_comb begin
    shifted  = dev_rdata << {off, 3'b000};
    asm_next = (asm_q & ~m64) | (shifted & m64);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (cap) begin
      asm_q <= asm_next;
    end
  end

endmodule

// File: rtl/rba_errlog.sv
module rba_errlog #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr
);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              upd;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    if (clr) begin
      valid_d = 1'b0;
    end else if (hit && log_en && !valid_q) begin
      valid_d = 1'b1;
      addr_d  = hit_addr;
    end
    upd = clr || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (upd) begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign log_valid = valid_q;
  assign log_addr  = addr_q;

  AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> (valid_q && $stable(addr_q))); // R9

endmodule

// File: rtl/rba_seq.sv
module rba_seq
  import rba_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_burst,
  input  logic [63:0]       req_wdata,
  input  logic              wr_legal,
  input  logic [1:0]        cfg_width,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              req_ready,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_cs_n,
  output logic              dev_oe_n,
  output logic              dev_we_n,
  output logic [63:0]       dev_wdata,
  output logic [1:0]        width_o,
  output logic [2:0]        off_o,
  output logic              cap_o,
  output logic              dw_done_o,
  output logic              txn_last_o,
  output logic              wr_done_o,
  output logic              err_acc_o
);

  localparam int DWA = ADDR_W - 3;

  seq_state_e        state_q, state_d;
  logic [DWA-1:0]    addr_dw_q, addr_dw_d;
  logic [2:0]        off_q, off_d;
  logic [1:0]        width_q, width_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [1:0]        beats_q, beats_d;
  logic [1:0]        wrap_q, wrap_d;
  logic              is_wr_q, is_wr_d;
  logic [63:0]       wdata_q, wdata_d;

  logic [3:0] bytes;
  logic       step_end;
  logic       slot_last;
  logic       accept;
  logic       err_acc;
  logic       go;
  logic       active;
  logic       en;
  logic [1:0] dw_lo_next;

  always_comb begin
    bytes      = width_bytes(width_q);
    active     = (state_q == ST_ACT);
    step_end   = (wcnt_q == wait_q);
    slot_last  = (({1'b0, off_q} + bytes) == 4'd8);
    accept     = req_valid && (state_q == ST_IDLE);
    err_acc    = accept && req_write && !wr_legal;
    go         = accept && !err_acc;
    en         = go || active;
    dw_lo_next = (addr_dw_q[1:0] & ~wrap_q) | ((addr_dw_q[1:0] + 2'd1) & wrap_q);
  end

  // next state
  always_comb begin
    state_d   = state_q;
    addr_dw_d = addr_dw_q;
    off_d     = off_q;
    width_d   = width_q;
    wait_d    = wait_q;
    wcnt_d    = wcnt_q;
    beats_d   = beats_q;
    wrap_d    = wrap_q;
    is_wr_d   = is_wr_q;
    wdata_d   = wdata_q;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d   = ST_ACT;
          is_wr_d   = req_write;
          width_d   = cfg_width;
          wait_d    = cfg_wait;
          wcnt_d    = '0;
          addr_dw_d = req_addr[ADDR_W-1:3];
          beats_d   = burst_wrap(req_burst);
          wrap_d    = burst_wrap(req_burst);
          if (req_write) begin
            off_d   = req_addr[2:0];
            wdata_d = req_wdata >> {req_addr[2:0], 3'b000};
          end else begin
            off_d   = 3'd0;
          end
        end
      end
      default: begin
        if (!step_end) begin
          wcnt_d = wcnt_q + 1'b1;
        end else begin
          wcnt_d = '0;
          if (is_wr_q) begin
            state_d = ST_IDLE;
          end else if (slot_last) begin
            off_d = 3'd0;
            if (beats_q == 2'd0) begin
              state_d = ST_IDLE;
            end else begin
              beats_d   = beats_q - 2'd1;
              addr_dw_d = {addr_dw_q[DWA-1:2], dw_lo_next};
            end
          end else begin
            off_d = off_q + bytes[2:0];
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_dw_q <= '0;
      off_q     <= '0;
      width_q   <= '0;
      wait_q    <= '0;
      wcnt_q    <= '0;
      beats_q   <= '0;
      wrap_q    <= '0;
      is_wr_q   <= 1'b0;
      wdata_q   <= '0;
    end else if (en) begin
      state_q   <= state_d;
      addr_dw_q <= addr_dw_d;
      off_q     <= off_d;
      width_q   <= width_d;
      wait_q    <= wait_d;
      wcnt_q    <= wcnt_d;
      beats_q   <= beats_d;
      wrap_q    <= wrap_d;
      is_wr_q   <= is_wr_d;
      wdata_q   <= wdata_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign dev_addr   = {addr_dw_q, off_q};
  assign dev_cs_n   = !active;
  assign dev_oe_n   = !(active && !is_wr_q);
  assign dev_we_n   = !(active && is_wr_q);
  assign dev_wdata  = wdata_q;
  assign width_o    = width_q;
  assign off_o      = off_q;
  assign cap_o      = active && !is_wr_q && step_end;
  assign dw_done_o  = cap_o && slot_last;
  assign txn_last_o = dw_done_o && (beats_q == 2'd0);
  assign wr_done_o  = active && is_wr_q && step_end;
  assign err_acc_o  = err_acc;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step_end) |=> (state_q == ST_ACT && $stable(dev_addr))); // R5

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> width_aligned(width_q, off_q)); // R2

  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_acc |=> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/rombus_adapter.sv
module rombus_adapter
  import rba_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_log_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_burst,
  input  logic [7:0]        req_be,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_last,
  output logic              rsp_sel_err,
  output logic              rsp_wr_err,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_cs_n,
  output logic              dev_oe_n,
  output logic              dev_we_n,
  output logic [63:0]       dev_wdata,
  input  logic [63:0]       dev_rdata,
  input  logic              log_clr,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr
);

  logic        wr_legal;
  logic [1:0]  cur_width;
  logic [2:0]  cur_off;
  logic        cap;
  logic        dw_done;
  logic        txn_last;
  logic        wr_done;
  logic        err_acc;
  logic [63:0] asm_next;

  logic        rsp_valid_q, rsp_valid_d;
  logic        rsp_last_q, rsp_last_d;
  logic        rsp_err_q, rsp_err_d;
  logic [63:0] rsp_data_q;

  rba_wr_check u_wr_check (
    .width   (cfg_width),
    .addr_lo (req_addr[2:0]),
    .burst   (req_burst),
    .be      (req_be),
    .legal   (wr_legal)
  );

  rba_seq #(
    .ADDR_W (ADDR_W),
    .WAIT_W (WAIT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_burst  (req_burst),
    .req_wdata  (req_wdata),
    .wr_legal   (wr_legal),
    .cfg_width  (cfg_width),
    .cfg_wait   (cfg_wait),
    .req_ready  (req_ready),
    .dev_addr   (dev_addr),
    .dev_cs_n   (dev_cs_n),
    .dev_oe_n   (dev_oe_n),
    .dev_we_n   (dev_we_n),
    .dev_wdata  (dev_wdata),
    .width_o    (cur_width),
    .off_o      (cur_off),
    .cap_o      (cap),
    .dw_done_o  (dw_done),
    .txn_last_o (txn_last),
    .wr_done_o  (wr_done),
    .err_acc_o  (err_acc)
  );

  rba_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap),
    .width     (cur_width),
    .off       (cur_off),
    .dev_rdata (dev_rdata),
    .asm_next  (asm_next)
  );

  rba_errlog #(
    .ADDR_W (ADDR_W)
  ) u_errlog (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_en    (cfg_log_en),
    .clr       (log_clr),
    .hit       (err_acc),
    .hit_addr  (req_addr),
    .log_valid (log_valid),
    .log_addr  (log_addr)
  );

  always_comb begin
    rsp_valid_d = dw_done || wr_done || err_acc;
    rsp_last_d  = txn_last || wr_done || err_acc;
    rsp_err_d   = err_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_last_q  <= rsp_last_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q <= '0;
    end else if (dw_done) begin
      rsp_data_q <= asm_next;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_last    = rsp_last_q;
  assign rsp_sel_err = rsp_err_q;
  assign rsp_wr_err  = rsp_err_q;
  assign rsp_data    = rsp_data_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_cs_n |-> (dev_oe_n != dev_we_n)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cs_n |-> (dev_oe_n && dev_we_n)); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sel_err |-> (rsp_valid && rsp_last && dev_cs_n && $past(req_ready))); // R8

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_cs_n |-> !req_ready); // R10

endmodule

// File: tb/rombus_adapter_bench.sv
`timescale 1ns/1ps
module rombus_adapter_bench;

  localparam int AW = 16;
  localparam int WW = 4;

  typedef struct {
    logic [63:0] data;
    bit          chk_data;
    bit          last;
    bit          err;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_width;
  logic [WW-1:0] cfg_wait;
  logic          cfg_log_en;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_burst;
  logic [7:0]    req_be;
  logic [63:0]   req_wdata;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          rsp_last;
  logic          rsp_sel_err;
  logic          rsp_wr_err;
  logic [AW-1:0] dev_addr;
  logic          dev_cs_n;
  logic          dev_oe_n;
  logic          dev_we_n;
  logic [63:0]   dev_wdata;
  logic [63:0]   dev_rdata;
  logic          log_clr;
  logic          log_valid;
  logic [AW-1:0] log_addr;

  exp_t        sb_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  int          cs_cnt = 0;
  logic [AW-1:0] wr_addr_seen;
  logic [63:0]   wr_data_seen;

  always #4 clk = ~clk;

  rombus_adapter #(
    .ADDR_W (AW),
    .WAIT_W (WW)
  ) u_rombus_adapter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_width   (cfg_width),
    .cfg_wait    (cfg_wait),
    .cfg_log_en  (cfg_log_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_burst   (req_burst),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_last    (rsp_last),
    .rsp_sel_err (rsp_sel_err),
    .rsp_wr_err  (rsp_wr_err),
    .dev_addr    (dev_addr),
    .dev_cs_n    (dev_cs_n),
    .dev_oe_n    (dev_oe_n),
    .dev_we_n    (dev_we_n),
    .dev_wdata   (dev_wdata),
    .dev_rdata   (dev_rdata),
    .log_clr     (log_clr),
    .log_valid   (log_valid),
    .log_addr    (log_addr)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // device model: low lanes carry data, upper lanes carry filler
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (i < (1 << cfg_width)) dev_rdata[i*8 +: 8] = byte_at(dev_addr + 16'(i));
      else                      dev_rdata[i*8 +: 8] = 8'hA5;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // device activity monitor
  always @(negedge clk) begin
    if (rst_n && !dev_cs_n) cs_cnt++;
    if (rst_n && !dev_we_n) begin
      wr_addr_seen = dev_addr;
      wr_data_seen = dev_wdata;
    end
  end

  // response monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk_data) check(rsp_data == e.data, e.tag, "read data", rsp_data, e.data);
        check(rsp_last == e.last, "R10", "last flag", 64'(rsp_last), 64'(e.last));
        check(rsp_sel_err == e.err && rsp_wr_err == e.err, e.tag, "error flags",
              64'({rsp_sel_err, rsp_wr_err}), 64'({e.err, e.err}));
      end
    end
  end

  task automatic do_req(input bit wr, input logic [15:0] addr, input logic [1:0] burst,
                        input logic [7:0] be, input logic [63:0] wd, input string tag);
    int   bw;
    int   nb;
    int   w;
    int   exp_cs;
    bit   legal;
    logic [7:0]  m;
    logic [63:0] m64;
    exp_t e;
    bw = 1 << cfg_width;
    w  = int'(cfg_wait);
    nb = (burst == 2'b00) ? 1 : (burst == 2'b01) ? 2 : 4;
    m  = 8'((1 << bw) - 1) << addr[2:0];
    legal = (burst == 2'b00) && ((int'(addr) % bw) == 0) && (be == m);
    if (!wr) begin
      for (int k = 0; k < nb; k++) begin
        int dw;
        int dwa;
        dw  = int'(addr) >> 3;
        dwa = (dw & ~(nb - 1)) | (((dw & (nb - 1)) + k) % nb);
        for (int j = 0; j < 8; j++) e.data[j*8 +: 8] = byte_at(16'(dwa * 8 + j));
        e.chk_data = 1'b1;
        e.last     = (k == nb - 1);
        e.err      = 1'b0;
        e.tag      = tag;
        sb_q.push_back(e);
      end
      exp_cs = nb * (8 / bw) * (w + 1);
    end else begin
      e.data = '0; e.chk_data = 1'b0; e.last = 1'b1; e.err = !legal; e.tag = tag;
      sb_q.push_back(e);
      exp_cs = legal ? (w + 1) : 0;
    end
    @(negedge clk);
    cs_cnt       = 0;
    wr_addr_seen = 16'hFFFF;
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    req_burst = burst; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!(wr && !legal))
      check(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    if (!wr)        check(cs_cnt == exp_cs, "R2", "device clocks", 64'(cs_cnt), 64'(exp_cs));
    else if (legal) check(cs_cnt == exp_cs, "R5", "write clocks", 64'(cs_cnt), 64'(exp_cs));
    else            check(cs_cnt == 0, "R8", "no device cycle", 64'(cs_cnt), 64'd0);
    if (wr && legal) begin
      m64 = (bw == 8) ? '1 : ((64'd1 << (8 * bw)) - 64'd1);
      check(wr_addr_seen == addr, "R7", "write address", 64'(wr_addr_seen), 64'(addr));
      check((wr_data_seen & m64) == ((wd >> (8 * addr[2:0])) & m64), "R7", "write data",
            wr_data_seen & m64, (wd >> (8 * addr[2:0])) & m64);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_width = 2'd0; cfg_wait = '0; cfg_log_en = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_burst = 2'b00;
    req_be = '0; req_wdata = '0; log_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R10", "no response after reset", 64'(rsp_valid), 64'd0);
    check(dev_cs_n && dev_oe_n && dev_we_n, "R6", "strobes idle", 64'({dev_cs_n, dev_oe_n, dev_we_n}), 64'd7);
    check(log_valid == 1'b0, "R9", "log empty", 64'(log_valid), 64'd0);

    // single reads on every width, partial byte enables (R1, R2, R5)
    for (int wv = 0; wv < 4; wv++) begin
      cfg_width = 2'(wv);
      cfg_wait  = 4'd0;
      do_req(1'b0, 16'h0123, 2'b00, 8'h08, '0, "R1");
      cfg_wait  = 4'd2;
      do_req(1'b0, 16'h1A5F, 2'b00, 8'h01, '0, "R1");
    end

    // two-beat bursts wrapping in 16 bytes (R3)
    cfg_width = 2'd1; cfg_wait = 4'd1;
    do_req(1'b0, 16'h0048, 2'b01, 8'hFF, '0, "R3");
    cfg_width = 2'd3; cfg_wait = 4'd0;
    do_req(1'b0, 16'h0730, 2'b01, 8'hFF, '0, "R3");

    // four-beat bursts wrapping in 32 bytes (R4)
    cfg_width = 2'd2; cfg_wait = 4'd0;
    do_req(1'b0, 16'h00F0, 2'b10, 8'hFF, '0, "R4");
    cfg_width = 2'd0; cfg_wait = 4'd3;
    do_req(1'b0, 16'h2278, 2'b11, 8'hFF, '0, "R4");

    // legal writes (R7)
    cfg_wait = 4'd1;
    cfg_width = 2'd0; do_req(1'b1, 16'h0205, 2'b00, 8'h20, 64'h0011223344556677, "R7");
    cfg_width = 2'd1; do_req(1'b1, 16'h0206, 2'b00, 8'hC0, 64'h8899AABBCCDDEEFF, "R7");
    cfg_width = 2'd2; do_req(1'b1, 16'h0204, 2'b00, 8'hF0, 64'h0123456789ABCDEF, "R7");
    cfg_width = 2'd3; do_req(1'b1, 16'h0200, 2'b00, 8'hFF, 64'hFEDCBA9876543210, "R7");

    // illegal writes with logging (R8, R9)
    cfg_log_en = 1'b1;
    cfg_width = 2'd1; do_req(1'b1, 16'h0301, 2'b00, 8'h06, '1, "R8");
    check(log_valid == 1'b1, "R9", "log set", 64'(log_valid), 64'd1);
    check(log_addr == 16'h0301, "R9", "log addr", 64'(log_addr), 64'h0301);
    cfg_width = 2'd2; do_req(1'b1, 16'h0310, 2'b00, 8'h03, '1, "R8");
    cfg_width = 2'd0; do_req(1'b1, 16'h0320, 2'b01, 8'h01, '1, "R8");
    check(log_addr == 16'h0301, "R9", "log keeps first", 64'(log_addr), 64'h0301);
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    check(log_valid == 1'b0, "R9", "log cleared", 64'(log_valid), 64'd0);
    cfg_log_en = 1'b0;
    cfg_width = 2'd3; do_req(1'b1, 16'h0344, 2'b00, 8'hFF, '1, "R8");
    check(log_valid == 1'b0, "R9", "log disabled", 64'(log_valid), 64'd0);

    // read after errors still works (R1)
    cfg_width = 2'd0; cfg_wait = 4'd0;
    do_req(1'b0, 16'h0400, 2'b00, 8'hFF, '0, "R1");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule